// File: doc/BRIEF.md
# Single-Pair PHY Link Sequencer

This block is the top-level control state machine of a full-duplex single-pair PHY that runs as either master or slave. It takes the PHY from a disabled state through an initialisation step. The master then transmits and waits until the slave is heard, and then acquires phase. The slave stays silent while it recovers the master's clock. Both then train, and the sequence ends in data mode. The receiver and equalizer algorithms sit elsewhere. This block only sees their status flags and tells the line driver whether to stay silent or send data.

Two countdown timers advance on a symbol-rate enable. A minimum-wait timer restarts each time a timed state is entered, and no forward move out of that state can happen until it has run out. A maximum-wait timer starts when initialisation is entered. If it runs out before data mode is reached, the sequence is abandoned and the machine falls back to disabled. Dropping the link enable returns the machine to disabled from any state.

Top module: `phy_link_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, the state output is 0 (OFF), `tx_send` is 0 and `link_up` is 0. The state codes are OFF=0, INIT=1, SLAVE_CLOCK=2, MASTER_TX=3, MASTER_PHASE=4, TRAIN=5 and DATA=6.
- R2: When `link_en` is sampled low at a clock edge, the state is OFF after that edge, whatever the state was. This takes priority over every other transition.
- R3: OFF moves to INIT only on an edge where `link_en` and `an_done` are both 1. Entering INIT loads the maximum-wait timer with MAX_WAIT.
- R4: INIT lasts exactly one cycle. The next state is MASTER_TX (3) if `is_master` is 1 and SLAVE_CLOCK (2) if it is 0.
- R5: MASTER_TX moves to MASTER_PHASE (4) on an edge where `peer_tx_seen` is 1 and the minimum-wait timer has expired.
- R6: MASTER_PHASE moves to TRAIN on `phase_lock` with the minimum-wait timer expired. SLAVE_CLOCK moves to TRAIN on `clock_lock` with the minimum-wait timer expired.
- R7: TRAIN moves to DATA only when `rx_ok`, `snr_ok` and `peer_ready` are all 1 and the minimum-wait timer has expired. If any of the three is 0, the machine stays in TRAIN. DATA is left only through R2.
- R8: Entering any of the states 2 to 6 reloads the minimum-wait timer with MIN_WAIT. The timer counts down one step per cycle with `sym_en` high. A forward transition is possible only after MIN_WAIT such enables since entry.
- R9: In states 2 to 5, if the maximum-wait timer reaches zero (MAX_WAIT enables after INIT entry), the next state is OFF. This takes priority over any forward transition. It has no effect in DATA.
- R10: `tx_send` is 1 (send data) in states 3, 4, 5 and 6, and 0 (silent) in states 0, 1 and 2.
- R11: `link_up` is 1 exactly when the state is DATA (6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_en | input | 1 | Symbol-rate enable that advances both timers |
| link_en | input | 1 | Link enable; low forces OFF |
| an_done | input | 1 | Autonegotiation complete |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| peer_tx_seen | input | 1 | Master has detected slave transmission |
| phase_lock | input | 1 | Master phase acquisition OK |
| clock_lock | input | 1 | Slave clock acquisition OK |
| rx_ok | input | 1 | Local receiver status OK |
| snr_ok | input | 1 | Local SNR margin OK |
| peer_ready | input | 1 | Remote PHY ready |
| state_o | output | 3 | Current state code (see R1) |
| tx_send | output | 1 | 1 = send data, 0 = silent |
| link_up | output | 1 | High in data mode |

## Verification
The state is registered, so any change in inputs sampled at an edge shows on `state_o` right after that edge. `tx_send` and `link_up` are decoded from the state without a further register, so they change in the same cycle. A timer expiry takes one cycle longer: the MIN_WAIT-th or MAX_WAIT-th enable empties the counter at one edge, and the state moves at the following edge. The bench keeps a behavioural model that advances on the same edge from the same sampled inputs. It compares all three outputs at every falling edge, half a cycle after the update. Directed checks wait on the model's state and then compare the outputs with fixed codes.

// File: rtl/lseq_pkg.sv
package lseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_INIT      = 3'd1,
        ST_SLV_CLK   = 3'd2,
        ST_MST_TX    = 3'd3,
        ST_MST_PHASE = 3'd4,
        ST_TRAIN     = 3'd5,
        ST_DATA      = 3'd6
    } lseq_state_e;

    typedef struct packed {
        lseq_state_e state;
    } lseq_regs_t;

endpackage

// File: rtl/lseq_wait_timer.sv
module lseq_wait_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    output logic done
);
    localparam int W = $clog2(LEN + 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = W'(LEN);
        end else if (tick && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = (tmr_q.cnt == '0);

    AST_TMR_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8
    AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done); // R8

endmodule

// File: rtl/lseq_tx_map.sv
module lseq_tx_map
    import lseq_pkg::*;
(
    input  lseq_state_e state,
    output logic        send,
    output logic        up
);
    always_comb begin
        send = 1'b0;
        up   = 1'b0;
        case (state)
            ST_MST_TX, ST_MST_PHASE, ST_TRAIN: send = 1'b1;
            ST_DATA: begin
                send = 1'b1;
                up   = 1'b1;
            end
            default: send = 1'b0;
        endcase
    end
endmodule

// File: rtl/phy_link_sequencer.sv
module phy_link_sequencer
    import lseq_pkg::*;
#(
    parameter int MIN_WAIT = 16,
    parameter int MAX_WAIT = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_en,
    input  logic       link_en,
    input  logic       an_done,
    input  logic       is_master,
    input  logic       peer_tx_seen,
    input  logic       phase_lock,
    input  logic       clock_lock,
    input  logic       rx_ok,
    input  logic       snr_ok,
    input  logic       peer_ready,
    output logic [2:0] state_o,
    output logic       tx_send,
    output logic       link_up
);
    lseq_regs_t seq_d, seq_q;
    logic min_start, max_start;
    logic min_done, max_done;
    logic in_acq;

    lseq_wait_timer #(.LEN(MIN_WAIT)) i_min_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sym_en),
        .start (min_start),
        .done  (min_done)
    );

    lseq_wait_timer #(.LEN(MAX_WAIT)) i_max_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sym_en),
        .start (max_start),
        .done  (max_done)
    );

    always_comb begin
        seq_d = seq_q;
        if (!link_en) begin
            seq_d.state = ST_OFF;
        end else begin
            case (seq_q.state)
                ST_OFF:       if (an_done) seq_d.state = ST_INIT;
                ST_INIT:      seq_d.state = is_master ? ST_MST_TX : ST_SLV_CLK;
                ST_SLV_CLK: begin
                    if (max_done)                    seq_d.state = ST_OFF;
                    else if (clock_lock && min_done) seq_d.state = ST_TRAIN;
                end
                ST_MST_TX: begin
                    if (max_done)                      seq_d.state = ST_OFF;
                    else if (peer_tx_seen && min_done) seq_d.state = ST_MST_PHASE;
                end
                ST_MST_PHASE: begin
                    if (max_done)                    seq_d.state = ST_OFF;
                    else if (phase_lock && min_done) seq_d.state = ST_TRAIN;
                end
                ST_TRAIN: begin
                    if (max_done) seq_d.state = ST_OFF;
                    else if (rx_ok && snr_ok && peer_ready && min_done)
                        seq_d.state = ST_DATA;
                end
                ST_DATA:      seq_d.state = ST_DATA;
                default:      seq_d.state = ST_OFF;
            endcase
        end
        min_start = (seq_d.state != seq_q.state) &&
                    (seq_d.state inside {ST_SLV_CLK, ST_MST_TX, ST_MST_PHASE,
                                         ST_TRAIN, ST_DATA});
        max_start = (seq_d.state == ST_INIT) && (seq_q.state != ST_INIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_OFF;
        end else begin
            seq_q <= seq_d;
        end
    end

    lseq_tx_map i_tx_map (
        .state (seq_q.state),
        .send  (tx_send),
        .up    (link_up)
    );

    assign state_o = seq_q.state;
    assign in_acq  = seq_q.state inside {ST_SLV_CLK, ST_MST_TX, ST_MST_PHASE, ST_TRAIN};

    AST_DROP_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (state_o == 3'd0)); // R2
    AST_OFF_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_OFF && !an_done) |=> (state_o == 3'd0)); // R3
    AST_INIT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_INIT && link_en && is_master) |=> (state_o == 3'd3)); // R4
    AST_INIT_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_INIT && link_en && !is_master) |=> (state_o == 3'd2)); // R4
    AST_MIN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acq && !min_done && !max_done && link_en) |=> $stable(state_o)); // R8
    AST_MAX_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_acq && max_done) |=> (state_o == 3'd0)); // R9
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_DATA && link_en) |=> (state_o == 3'd6)); // R7
    AST_TRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_TRAIN && link_en && !max_done && !(rx_ok && snr_ok && peer_ready))
        |=> (state_o == 3'd5)); // R7
    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_SLV_CLK) |-> !tx_send); // R10

endmodule

// File: tb/test_phy_link_sequencer.sv
module test_phy_link_sequencer;
    localparam int MINW = 4;
    localparam int MAXW = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_en = 1'b0;
    logic link_en = 1'b0, an_done = 1'b0, is_master = 1'b0;
    logic peer_tx_seen = 1'b0, phase_lock = 1'b0, clock_lock = 1'b0;
    logic rx_ok = 1'b0, snr_ok = 1'b0, peer_ready = 1'b0;
    logic [2:0] state_o;
    logic tx_send, link_up;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int div = 0;
    string cur_req = "R1";

    int m_st = 0, m_mn = 0, m_mx = 0;

    always #2 clk = ~clk;

    phy_link_sequencer #(.MIN_WAIT(MINW), .MAX_WAIT(MAXW)) i_phy_link_sequencer (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .link_en(link_en),
        .an_done(an_done), .is_master(is_master), .peer_tx_seen(peer_tx_seen),
        .phase_lock(phase_lock), .clock_lock(clock_lock), .rx_ok(rx_ok),
        .snr_ok(snr_ok), .peer_ready(peer_ready), .state_o(state_o),
        .tx_send(tx_send), .link_up(link_up)
    );

    // symbol enable: one cycle in three
    always @(negedge clk) begin
        div    <= (div == 2) ? 0 : div + 1;
        sym_en <= (div == 2);
    end

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_mn = 0; m_mx = 0;
        end else begin
            int nx;
            nx = m_st;
            if (!link_en) nx = 0;
            else if (m_st == 0) nx = an_done ? 1 : 0;
            else if (m_st == 1) nx = is_master ? 3 : 2;
            else if (m_st == 6) nx = 6;
            else if (m_mx == 0) nx = 0;
            else if (m_mn == 0) begin
                if (m_st == 2 && clock_lock) nx = 5;
                if (m_st == 3 && peer_tx_seen) nx = 4;
                if (m_st == 4 && phase_lock) nx = 5;
                if (m_st == 5 && rx_ok && snr_ok && peer_ready) nx = 6;
            end
            if (nx != m_st && nx >= 2) m_mn = MINW;
            else if (sym_en && m_mn > 0) m_mn = m_mn - 1;
            if (nx == 1 && m_st != 1) m_mx = MAXW;
            else if (sym_en && m_mx > 0) m_mx = m_mx - 1;
            m_st = nx;
        end
    end

    function automatic bit exp_tx(int s);
        return (s >= 3 && s <= 6);
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against model (R10 tx decode, R11 link_up)
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(cur_req, state_o, m_st, "state");
            chk("R10", tx_send, exp_tx(m_st), "tx_send");
            chk("R11", link_up, (m_st == 6), "link_up");
        end
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_model(int s, int limit);
        for (int i = 0; i < limit; i++) begin
            if (m_st == s) return;
            @(negedge clk);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        chk("R1", state_o, 0, "reset state");
        chk("R1", tx_send, 0, "reset tx");
        rst_n = 1'b1;
        idle(2);
        chk("R1", state_o, 0, "post reset state");
        chk("R11", link_up, 0, "post reset up");

        // R3: link_en without an_done stays OFF
        cur_req = "R3";
        link_en = 1'b1;
        idle(5);
        chk("R3", state_o, 0, "no an_done");

        // master path, peer seen early: min timer gates (R5, R8)
        cur_req = "R5";
        is_master = 1'b1; peer_tx_seen = 1'b1;
        an_done = 1'b1;
        @(negedge clk);
        chk("R3", state_o, 1, "enter INIT");
        @(negedge clk);
        chk("R4", state_o, 3, "master after INIT");
        chk("R10", tx_send, 1, "master tx");
        idle(2);
        chk("R8", state_o, 3, "min wait holds MASTER_TX");
        wait_model(4, 40);
        chk("R5", state_o, 4, "MASTER_PHASE");
        cur_req = "R6";
        idle(3);
        phase_lock = 1'b1;
        wait_model(5, 40);
        chk("R6", state_o, 5, "master TRAIN");
        cur_req = "R7";
        rx_ok = 1'b1; snr_ok = 1'b1;
        idle(20);
        chk("R7", state_o, 5, "TRAIN holds without peer_ready");
        peer_ready = 1'b1;
        wait_model(6, 40);
        chk("R7", state_o, 6, "DATA");
        chk("R11", link_up, 1, "link up");
        idle(300);
        chk("R9", state_o, 6, "max timer ignored in DATA");

        // R2: drop from DATA
        cur_req = "R2";
        link_en = 1'b0;
        @(negedge clk);
        chk("R2", state_o, 0, "drop from DATA");

        // slave path
        cur_req = "R6";
        is_master = 1'b0; peer_tx_seen = 1'b0; phase_lock = 1'b0;
        peer_ready = 1'b0;
        link_en = 1'b1;
        idle(2);
        chk("R4", state_o, 2, "slave after INIT");
        chk("R10", tx_send, 0, "slave silent");
        idle(20);
        chk("R6", state_o, 2, "slave waits for clock_lock");
        clock_lock = 1'b1;
        wait_model(5, 40);
        chk("R6", state_o, 5, "slave TRAIN");
        peer_ready = 1'b1;
        wait_model(6, 40);
        chk("R7", state_o, 6, "slave DATA");

        // R2 from MASTER_PHASE
        cur_req = "R2";
        link_en = 1'b0; clock_lock = 1'b0; peer_ready = 1'b0;
        @(negedge clk);
        is_master = 1'b1; peer_tx_seen = 1'b1; link_en = 1'b1;
        wait_model(4, 60);
        chk("R5", state_o, 4, "second MASTER_PHASE");
        link_en = 1'b0;
        @(negedge clk);
        chk("R2", state_o, 0, "drop from MASTER_PHASE");

        // R9: max timer abort, slave never gets clock
        cur_req = "R9";
        is_master = 1'b0; peer_tx_seen = 1'b0;
        link_en = 1'b1;
        idle(2);
        chk("R4", state_o, 2, "slave for timeout");
        idle(3 * MAXW - 20);
        chk("R9", state_o, 2, "before max expiry");
        wait_model(0, 60);
        chk("R9", state_o, 0, "max expiry to OFF");
        @(negedge clk);
        chk("R3", state_o, 1, "re-enter INIT");
        an_done = 1'b0;
        link_en = 1'b0;
        idle(3);
        chk("R2", state_o, 0, "final off");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule